// File: doc/BRIEF.md
# Per-Channel Variable-Length Delta Encoder

This block compresses a stream of 32-bit signed samples that arrive interleaved from several channels. For each accepted sample it subtracts the value last seen on the same channel and emits the difference as a self-describing code word of one, two, three or four bytes. The high bits of each code word are a length tag, so a downstream byte packer can split the stream and a decoder can parse it. Small changes get short codes and large jumps get long ones. The block stores the previous value of every channel and replaces it with each new sample.

One sample can be offered per clock on `in_valid`. Its code appears exactly one cycle later together with `out_valid`. The code is right-aligned in `out_code`. `out_bytes` gives the length, and two flags mark the shortest and the longest size. The number of channels is a parameter. A channel index at or above `NUM_CH` is dropped: it produces no output and changes no history. The control is a two-state machine. `ST_IDLE` means no code is presented. `ST_EMIT` means the code registers hold a code for one cycle. The transition to `ST_EMIT` is taken on an accepted sample, and the transition to `ST_IDLE` is taken when no sample is accepted. Both transitions are possible from either state.

Top module: `dve_encoder`

## Requirements
- R1: After reset `out_valid` is 0 and every channel's stored previous value is 0, so the first sample on a channel is encoded as the sample itself.
- R2: A sample offered with `in_valid` high produces `out_valid` high on the next cycle only. A cycle with `in_valid` low produces `out_valid` low on the next cycle.
- R3: The difference is the new sample minus the value stored for the same channel. The new sample then replaces that stored value. Channels do not affect one another.
- R4: If the magnitude of the difference is below 0x40, `out_bytes` is 1 and `out_code` is the difference ANDed with 0x7F, with bits 31..7 zero.
- R5: If the magnitude is at least 0x40 and below 0x1000, `out_bytes` is 2 and `out_code` is (difference AND 0x1FFF) OR 0xC000, with bits 31..16 zero.
- R6: If the magnitude is at least 0x1000 and below 0x80000, `out_bytes` is 3 and `out_code` is (difference AND 0xFFFFF) OR 0xE00000, with bits 31..24 zero.
- R7: If the magnitude is 0x80000 or more, `out_bytes` is 4 and `out_code` is (difference AND 0x7FFFFFF) OR 0xF0000000.
- R8: `out_one` is high exactly when `out_bytes` is 1. `out_four` is high exactly when `out_bytes` is 4. Both flags are low for lengths 2 and 3.
- R9: Differences wrap modulo 2^32. The magnitude of a negative difference is 0 minus the difference and is compared as an unsigned number, so a difference of 0x80000000 takes the 4-byte code.
- R10: A sample on a channel in the cycle right after another sample on the same channel is differenced against that immediately preceding sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A sample is offered this cycle |
| in_chan | input | CH_W | Channel index of the offered sample |
| in_sample | input | 32 | Sample value, two's complement |
| out_valid | output | 1 | A code word is presented this cycle |
| out_code | output | 32 | Tagged code word, right-aligned |
| out_bytes | output | 3 | Code length in bytes, 1 to 4 |
| out_one | output | 1 | Code length is 1 byte |
| out_four | output | 1 | Code length is 4 bytes |

## Verification
A stale or corrupted history word does not show up on the sample that damages it. It shows up on the next sample of that channel, as a wrong difference, and often as a wrong length tag too. The bench therefore revisits every channel several times and interleaves channels, so that history faults surface within a few cycles. A wrong state or latency fault shows at once as an `out_valid` pulse in the wrong cycle. A threshold or masking fault shows only when a difference lies at the affected boundary, so each boundary is driven from both sides and with both signs.

// File: rtl/dve_pkg.sv
package dve_pkg;
    localparam int unsigned DATA_W = 32;

    localparam logic [DATA_W-1:0] LIM_ONE   = 32'h0000_0040;
    localparam logic [DATA_W-1:0] LIM_TWO   = 32'h0000_1000;
    localparam logic [DATA_W-1:0] LIM_THREE = 32'h0008_0000;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_3 = 2'd2,
        SZ_4 = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;
endpackage

// File: rtl/dve_history.sv
module dve_history #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2,
    parameter int unsigned DW     = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CH_W-1:0] chan,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] hist_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q[g] <= '0;
            end else if (wr_en && (int'(chan) == g)) begin
                hist_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (int'(chan) == i) begin
                rd_data = hist_q[i];
            end
        end
    end
endmodule

// File: rtl/dve_classify.sv
module dve_classify
    import dve_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] prev,
    output logic [DATA_W-1:0] code,
    output size_e             size
);
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] mag;

    always_comb begin
        diff = cur - prev;
        mag  = diff[DATA_W-1] ? (32'd0 - diff) : diff;
        if (mag < LIM_ONE) begin
            size = SZ_1;
            code = {25'd0, diff[6:0]};
        end else if (mag < LIM_TWO) begin
            size = SZ_2;
            code = {16'd0, 3'b110, diff[12:0]};
        end else if (mag < LIM_THREE) begin
            size = SZ_3;
            code = {8'd0, 4'b1110, diff[19:0]};
        end else begin
            size = SZ_4;
            code = {5'b11110, diff[26:0]};
        end
    end
endmodule

// File: rtl/dve_encoder.sv
module dve_encoder
    import dve_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [31:0]       in_sample,
    output logic              out_valid,
    output logic [31:0]       out_code,
    output logic [2:0]        out_bytes,
    output logic              out_one,
    output logic              out_four
);
    logic              accept;
    logic [DATA_W-1:0] prev_val;
    logic [DATA_W-1:0] code_c;
    size_e             size_c;
    emit_state_e       st_q, st_d;

    assign accept = in_valid && ({1'b0, in_chan} < (CH_W+1)'(NUM_CH));

    dve_history #(.NUM_CH(NUM_CH), .CH_W(CH_W), .DW(DATA_W)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .chan    (in_chan),
        .wr_data (in_sample),
        .rd_data (prev_val)
    );

    dve_classify u_cls (
        .cur  (in_sample),
        .prev (prev_val),
        .code (code_c),
        .size (size_c)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = accept ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_code  <= '0;
            out_bytes <= 3'd1;
            out_one   <= 1'b1;
            out_four  <= 1'b0;
        end else if (accept) begin
            out_code  <= code_c;
            out_bytes <= 3'(size_c) + 3'd1;
            out_one   <= (size_c == SZ_1);
            out_four  <= (size_c == SZ_4);
        end
    end

    assign out_valid = (st_q == ST_EMIT);
endmodule

// File: rtl/dve_encoder_checker.sv
module dve_encoder_checker #(
    parameter int unsigned CH_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [CH_W-1:0] in_chan,
    input logic [31:0]     in_sample,
    input logic            out_valid,
    input logic [31:0]     out_code,
    input logic [2:0]      out_bytes,
    input logic            out_one,
    input logic            out_four
);
    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    assert_idle_in_idle_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge && !in_valid |=> !out_valid);

    assert_bytes_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_bytes >= 3'd1 && out_bytes <= 3'd4));

    assert_flags_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_one == (out_bytes == 3'd1)) && (out_four == (out_bytes == 3'd4)));

    assert_short_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bytes == 3'd1 |-> out_code[31:7] == 25'd0);

    assert_tag_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bytes == 3'd2 |-> out_code[31:16] == 16'd0 && out_code[15:13] == 3'b110);

    assert_tag_three_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bytes == 3'd3 |-> out_code[31:24] == 8'd0 && out_code[23:20] == 4'b1110);

    assert_tag_four_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_bytes == 3'd4 |-> out_code[31:27] == 5'b11110);

    logic unused_ok;
    assign unused_ok = ^{in_chan, in_sample};
endmodule

bind dve_encoder dve_encoder_checker #(.CH_W(CH_W)) u_chk (.*);

// File: tb/dve_encoder_bench.sv
module dve_encoder_bench;
    localparam int NUM_CH = 4;
    localparam int CH_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [CH_W-1:0]   in_chan = '0;
    logic [31:0]       in_sample = '0;
    logic              out_valid;
    logic [31:0]       out_code;
    logic [2:0]        out_bytes;
    logic              out_one;
    logic              out_four;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] hist [NUM_CH];
    logic        exp_v = 1'b0;
    logic [31:0] exp_code = '0;
    logic [2:0]  exp_bytes = 3'd1;
    string       exp_tag = "R1";

    always #4 clk = ~clk;

    dve_encoder #(.NUM_CH(NUM_CH)) u_dve_encoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_sample(in_sample), .out_valid(out_valid), .out_code(out_code),
        .out_bytes(out_bytes), .out_one(out_one), .out_four(out_four)
    );

    function automatic logic [34:0] model(input logic [31:0] d);
        logic [31:0] m;
        m = d[31] ? (32'd0 - d) : d;
        if (m < 32'h40)         return {3'd1, d & 32'h7F};
        else if (m < 32'h1000)  return {3'd2, (d & 32'h1FFF) | 32'hC000};
        else if (m < 32'h80000) return {3'd3, (d & 32'hFFFFF) | 32'hE00000};
        else                    return {3'd4, (d & 32'h7FFFFFF) | 32'hF0000000};
    endfunction

    function automatic string size_tag(input logic [2:0] b);
        case (b)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check_prev();
        n_vec++;
        if (out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL R2 %s out_valid act=%0b exp=%0b", exp_tag, out_valid, exp_v);
        end else if (exp_v) begin
            if (out_code !== exp_code || out_bytes !== exp_bytes) begin
                n_bad++;
                $display("FAIL %s %s code/bytes act=%h/%0d exp=%h/%0d",
                         size_tag(exp_bytes), exp_tag, out_code, out_bytes, exp_code, exp_bytes);
            end else if (out_one !== (exp_bytes == 3'd1) || out_four !== (exp_bytes == 3'd4)) begin
                n_bad++;
                $display("FAIL R8 %s flags act=%0b%0b exp=%0b%0b", exp_tag, out_one, out_four,
                         exp_bytes == 3'd1, exp_bytes == 3'd4);
            end
        end
    endtask

    task automatic step(input logic v, input int ch, input logic [31:0] s, input string tag);
        logic [34:0] r;
        check_prev();
        in_valid  = v;
        in_chan   = CH_W'(ch);
        in_sample = s;
        exp_v     = v;
        exp_tag   = tag;
        if (v) begin
            r         = model(s - hist[ch]);
            exp_bytes = r[34:32];
            exp_code  = r[31:0];
            hist[ch]  = s;
        end
        @(negedge clk);
    endtask

    task automatic delta(input int ch, input logic [31:0] d, input string tag);
        step(1'b1, ch, hist[ch] + d, tag);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] bnd [12];
        for (int i = 0; i < NUM_CH; i++) hist[i] = '0;
        bnd = '{32'h3F, 32'h40, 32'hFFF, 32'h1000, 32'h7FFFF, 32'h80000,
                32'hFFFFFFC1, 32'hFFFFFFC0, 32'hFFFFF001, 32'hFFFFF000,
                32'hFFF80001, 32'hFFF80000};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, first sample differences against zero
        step(1'b0, 0, 32'd0, "R1");
        step(1'b1, 0, 32'd5, "R1");
        step(1'b1, 1, 32'hFFFF_FFFE, "R1");
        step(1'b0, 0, 32'd0, "R2");
        // boundaries on every channel, R4 R5 R6 R7
        for (int c = 0; c < NUM_CH; c++) begin
            for (int k = 0; k < 12; k++) begin
                delta(c, bnd[k], "boundary");
                step(1'b1, (c + 1) % NUM_CH, hist[(c + 1) % NUM_CH] + 32'd3, "R3");
            end
        end
        // R10: back-to-back on one channel
        step(1'b1, 2, 32'd1000, "R10");
        step(1'b1, 2, 32'd1001, "R10");
        step(1'b1, 2, 32'd1001, "R10");
        // R9: wraparound and the most negative difference
        step(1'b1, 3, 32'h7FFF_FFFF, "R9");
        step(1'b1, 3, 32'h8000_0000, "R9");
        step(1'b1, 3, 32'h0000_0000, "R9");
        step(1'b0, 0, 32'd0, "R2");
        // random mix, R3 across channels
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            int ch;
            logic [31:0] d;
            ch = int'($urandom_range(NUM_CH - 1));
            d  = 32'($signed($urandom()) >>> $urandom_range(31));
            if ($urandom_range(7) == 0) step(1'b0, ch, 32'd0, "R2");
            else                        delta(ch, d, "R3");
        end
        step(1'b0, 0, 32'd0, "R2");
        check_prev();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule